// File: doc/BRIEF.md
# Montgomery Domain Factor Calculator

This block derives the constant F = 2^(2L) mod N, with L the operand length in bits, which a Montgomery multiplier needs to move operands into its residue domain. The modulus N is written word by word into an internal buffer through a small write port. A start strobe then launches the computation. The result is left in an internal word buffer that is read through an asynchronous read port.

The block begins from F = 1 and performs 2L doubling steps. In each step one word-serial pass walks the words from least to most significant. For each word it forms the doubled word, with the top bit of the lower word moved in, and in the same cycle the trial difference of that word minus N minus the running borrow. The shifted words are written back into F and the differences go into a scratch buffer. At the end of the pass, the bit shifted out of the top word and the final borrow decide whether the doubled value stays or the difference replaces it. A second pass over the words performs that replacement. The busy output covers the whole run, and a one-cycle done pulse marks its end.

Top module: `mont_factor_calc`

## Requirements
- R1: After reset, busy and done are 0 and every word of the result buffer reads 0.
- R2: While idle, a write with n_we high stores n_wdata into modulus word n_addr. Word 0 is the least significant 32 bits of N.
- R3: A start pulse while idle begins a run, and in the cycle after that edge the result buffer holds 1: word 0 reads 1 and every other word reads 0.
- R4: For an odd modulus N > 1 whose most significant word is nonzero, the result buffer at the end of a run holds 2^(2L) mod N, with L = 32·NUM_WORDS and word 0 least significant.
- R5: busy stays high for exactly 2L·2·NUM_WORDS cycles after the start edge, with two passes of NUM_WORDS cycles for each of the 2L steps.
- R6: done is high for exactly one cycle. That cycle is the first one in which busy is low again after a run.
- R7: While busy, start pulses and modulus writes are ignored. The run length is unchanged, and a later run without reloading gives the same result.
- R8: Between runs the result buffer holds its value unchanged.
- R9: Moduli with the top bit set, where a doubled value overflows L bits, and moduli just above 2^(L-32) both give the correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_we | input | 1 | Modulus word write enable |
| n_addr | input | AW | Modulus word index |
| n_wdata | input | WORD_W | Modulus word data |
| start | input | 1 | Begin a computation |
| f_addr | input | AW | Result word index |
| f_rdata | output | WORD_W | Result word at f_addr |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions assume that the modulus is odd whenever a run is launched. The check that the final result lies below N also relies on N being larger than 1 with a nonzero top word. The bench therefore loads only odd moduli with a nonzero most significant word, including the all-ones value and a value with only the top bit and bit 0 set. The garbage words written during a run to probe R7 are never latched, so the stored modulus stays within these limits.

// File: rtl/mont_factor_calc.sv
module mont_factor_calc #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  localparam int AW       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              n_we,
  input  logic [AW-1:0]     n_addr,
  input  logic [WORD_W-1:0] n_wdata,
  input  logic              start,
  input  logic [AW-1:0]     f_addr,
  output logic [WORD_W-1:0] f_rdata,
  output logic              busy,
  output logic              done
);
  localparam int STEPS = 2 * NUM_WORDS * WORD_W;
  localparam int SW    = $clog2(STEPS + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_SEL} st_t;

  logic [WORD_W-1:0] n_mem [NUM_WORDS];
  logic [WORD_W-1:0] f_mem [NUM_WORDS];
  logic [WORD_W-1:0] t_mem [NUM_WORDS];
  st_t               st;
  logic [AW-1:0]     idx;
  logic [SW-1:0]     step;
  logic              cin, bin, keep_f;

  wire               last_word = (idx == AW'(NUM_WORDS - 1));
  wire               last_step = (step == SW'(STEPS - 1));
  wire [WORD_W-1:0]  cur_f     = f_mem[idx];
  wire [WORD_W-1:0]  shifted   = {cur_f[WORD_W-2:0], cin};
  wire [WORD_W:0]    diff      = {1'b0, shifted} - {1'b0, n_mem[idx]} - (WORD_W+1)'(bin);
  wire               bout      = diff[WORD_W];

  assign busy    = (st != S_IDLE);
  assign f_rdata = f_mem[f_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) n_mem[i] <= '0;
    end else if (n_we && st == S_IDLE) begin
      n_mem[n_addr] <= n_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        f_mem[i] <= '0;
        t_mem[i] <= '0;
      end
      st     <= S_IDLE;
      idx    <= '0;
      step   <= '0;
      cin    <= 1'b0;
      bin    <= 1'b0;
      keep_f <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          for (int i = 0; i < NUM_WORDS; i++) f_mem[i] <= (i == 0) ? WORD_W'(1) : '0;
          st   <= S_SHIFT;
          idx  <= '0;
          step <= '0;
          cin  <= 1'b0;
          bin  <= 1'b0;
        end
        S_SHIFT: begin
          f_mem[idx] <= shifted;
          t_mem[idx] <= diff[WORD_W-1:0];
          cin        <= cur_f[WORD_W-1];
          bin        <= bout;
          if (last_word) begin
            keep_f <= bout && !cur_f[WORD_W-1];
            idx    <= '0;
            st     <= S_SEL;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_SEL: begin
          if (!keep_f) f_mem[idx] <= t_mem[idx];
          if (last_word) begin
            idx <= '0;
            cin <= 1'b0;
            bin <= 1'b0;
            if (last_step) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              step <= step + 1'b1;
              st   <= S_SHIFT;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mont_factor_calc_chk.sv
module mont_factor_calc_chk #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] n_mem [NUM_WORDS],
  input logic [WORD_W-1:0] f_mem [NUM_WORDS]
);
  localparam int L = WORD_W * NUM_WORDS;
  logic [L-1:0] n_flat, f_flat;

  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++) begin
      n_flat[i*WORD_W +: WORD_W] = n_mem[i];
      f_flat[i*WORD_W +: WORD_W] = f_mem[i];
    end
  end

  a_r4_modulus_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |-> n_flat[0]);
  a_r3_init_one: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (f_flat == L'(1)));
  a_r4_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (f_flat < n_flat));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));
  a_r7_modulus_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(n_flat));
  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(f_flat));
endmodule

bind mont_factor_calc mont_factor_calc_chk #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .n_mem (n_mem),
  .f_mem (f_mem)
);

// File: tb/test_mont_factor_calc.sv
module test_mont_factor_calc;
  localparam int WORD_W = 32;
  localparam int NW     = 4;
  localparam int AW     = 2;
  localparam int L      = WORD_W * NW;
  localparam int TOTAL  = 2 * L * 2 * NW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic n_we = 1'b0, start = 1'b0;
  logic [AW-1:0] n_addr = '0, f_addr = '0;
  logic [WORD_W-1:0] n_wdata = '0, f_rdata;
  logic busy, done;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  mont_factor_calc #(.WORD_W(WORD_W), .NUM_WORDS(NW)) i_mont_factor_calc (
    .clk(clk), .rst_n(rst_n), .n_we(n_we), .n_addr(n_addr), .n_wdata(n_wdata),
    .start(start), .f_addr(f_addr), .f_rdata(f_rdata), .busy(busy), .done(done));

  // cycle model: remaining busy cycles and expected done
  int m_cnt = 0;
  logic m_done = 1'b0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  <= 0;
      m_done <= 1'b0;
    end else begin
      m_done <= (m_cnt == 1);
      if (m_cnt > 0) m_cnt <= m_cnt - 1;
      else if (start) m_cnt <= TOTAL;
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks += 2;
    if (busy !== (m_cnt != 0)) begin
      errors++;
      $display("FAIL R5 busy act=%0d exp=%0d", busy, (m_cnt != 0));
    end
    if (done !== m_done) begin
      errors++;
      $display("FAIL R6 done act=%0d exp=%0d", done, m_done);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load_n(input logic [L-1:0] v);
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      n_we = 1'b1; n_addr = AW'(i); n_wdata = v[i*WORD_W +: WORD_W];
    end
    @(negedge clk);
    n_we = 1'b0;
  endtask

  task automatic read_f(output logic [L-1:0] v);
    for (int i = 0; i < NW; i++) begin
      f_addr = AW'(i);
      #0.1;
      v[i*WORD_W +: WORD_W] = f_rdata;
    end
  endtask

  function automatic logic [L-1:0] ref_factor(input logic [L-1:0] n);
    logic [2*L:0] pw, md;
    pw = '0;
    pw[2*L] = 1'b1;
    md = pw % {{(L+1){1'b0}}, n};
    return md[L-1:0];
  endfunction

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < TOTAL + 100; c++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) begin
      errors++; checks++;
      $display("FAIL R6 watchdog act=0 exp=1");
    end
  endtask

  task automatic run(input logic [L-1:0] n, input string req, input bit disturb);
    logic [L-1:0] got, exp;
    bit ok;
    exp = ref_factor(n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    read_f(got);
    chk(got == L'(1), "R3 init", got, L'(1));
    if (disturb) begin
      repeat (37) @(negedge clk);
      start = 1'b1; n_we = 1'b1; n_addr = '0; n_wdata = 32'hDEAD_BEE0;
      @(negedge clk);
      start = 1'b0; n_we = 1'b0;
    end
    wait_done(ok);
    read_f(got);
    chk(got == exp, req, got, exp);
    repeat (10) @(negedge clk);
    read_f(got);
    chk(got == exp, "R8 hold", got, exp);
  endtask

  initial begin
    logic [L-1:0] v;
    repeat (3) @(negedge clk);
    read_f(v);
    chk(busy == 1'b0 && done == 1'b0, "R1 flags", {busy, done}, '0);
    chk(v == '0, "R1 result", v, '0);
    rst_n = 1'b1;
    @(negedge clk);
    load_n({L{1'b1}});
    run({L{1'b1}}, "R4 all-ones", 1'b0);
    load_n({32'h8000_0000, 64'h0, 32'h1});
    run({32'h8000_0000, 64'h0, 32'h1}, "R9 top-bit", 1'b0);
    load_n({32'h1, 64'h0, 32'h1});
    run({32'h1, 64'h0, 32'h1}, "R9 small-top", 1'b0);
    load_n(128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFF61);
    run(128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFF61, "R2 R4 loaded", 1'b1);
    run(128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFF61, "R7 ignored", 1'b0);
    load_n(128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6979);
    run(128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6979, "R4 mixed", 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule